// File: doc/BRIEF.md
# Gated Prescaled 16-bit Event Timer

This block is a 16-bit up-counter for a small peripheral subsystem. Each count step comes from one of two sources: a free-running internal tick that fires once every `TICK_DIV` system clocks (four by default), or rising edges on an external clock pin. The external path runs through a two-flop synchronizer by default, and a control bit can take one stage out of that path. A 2-bit field selects a prescaler of 1, 2, 4 or 8 source pulses per count step. A count gate can pause counting. It samples either a gate pin or a comparator result bit, and its active level can be programmed. When the count wraps, a sticky overflow flag is set. The interrupt line is that flag masked by an enable bit.

Software reaches the block through a byte-wide register port with a 2-bit address. A write takes effect on the next clock edge, and reads are combinational. The counting condition lives in a three-state machine. `ST_OFF` means the timer is disabled. `ST_RUN` means the timer counts. `ST_PAUSE` means the timer is enabled but the gate is closed. Every cycle the machine takes one of these transitions: *disable* (any state to `ST_OFF` when the on bit is 0), *start* (`ST_OFF` to `ST_RUN`), *start-held* (`ST_OFF` to `ST_PAUSE`), *close* (`ST_RUN` to `ST_PAUSE`), *open* (`ST_PAUSE` to `ST_RUN`) or *stay*. A count step is taken only in a cycle whose registered state is `ST_RUN`.

Top module: `gated_timer16`

## Requirements
- R1: After reset, address 0 reads 0x00, addresses 1 and 2 read 0x00, and address 3 reads 0x04 (gate select = 1, interrupt enable = 0, flag = 0), and `irq` is 0.
- R2: Address 0 is the control byte. Bit 7 is the gate level, bit 6 the gate enable, bits 5:4 the prescale select, bit 3 the oscillator-enable bit, bit 2 the synchronizer bypass, bit 1 the source select (1 = external) and bit 0 the on bit. Address 1 is the count low byte and address 2 the count high byte. At address 3, bit 0 is the overflow flag, bit 1 the interrupt enable and bit 2 the gate select, and bits 7:3 read 0. A write shows on reads from the next cycle on.
- R3: With source select 0, the source pulses once every 4 system clocks from a divider that runs freely from reset.
- R4: With source select 1, each rising edge of `ext_clk_pin` is one source pulse. With bypass 0 it passes three flops (edge seen on the third clock after the pin rises). With bypass 1 it passes two flops, one cycle earlier.
- R5: With the on bit 0 the count never changes, whatever the gate enable, gate level or gate inputs.
- R6: With the on bit 1 and gate enable 0 the timer counts freely. With gate enable 1 it counts only while the selected gate input equals the gate level bit. The gate is registered once before it affects counting.
- R7: Gate select 1 takes `cmp_level` as the gate and gate select 0 takes `gate_pin`.
- R8: Prescale select 00, 01, 10 and 11 give one count step per 1, 2, 4 and 8 source pulses taken in `ST_RUN`.
- R9: A write to address 0, 1 or 2 clears the prescaler. A write to address 1 or 2 loads that byte and overrides any count step in the same cycle.
- R10: A count step from 0xFFFF to 0x0000 sets the flag. The flag stays set until address 3 is written with bit 0 = 0. A wrap in the same cycle as such a write leaves the flag set.
- R11: `irq` equals the flag ANDed with the interrupt enable.
- R12: The oscillator-enable bit is stored and read back and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_clk_pin | input | 1 | External count clock |
| gate_pin | input | 1 | Gate pin input |
| cmp_level | input | 1 | Comparator result used as a gate |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `bus_we`, `bus_addr` and `bus_wdata` hold steady around each rising clock edge. They also assume that the gate and comparator inputs change only between edges, because the gate is sampled without a synchronizer. The bench drives every input on the falling edge to meet both assumptions. It toggles the external pin over several clocks, so no rising edge is shorter than the synchronizer can see.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOW  = 2'd1;
    localparam logic [1:0] A_HIGH = 2'd2;
    localparam logic [1:0] A_AUX  = 2'd3;

    localparam int B_ON     = 0;
    localparam int B_EXT    = 1;
    localparam int B_BYPASS = 2;
    localparam int B_OSC    = 3;
    localparam int B_PS_LO  = 4;
    localparam int B_PS_HI  = 5;
    localparam int B_GEN    = 6;
    localparam int B_GLVL   = 7;

    localparam int X_FLAG = 0;
    localparam int X_IE   = 1;
    localparam int X_GSEL = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } gate_state_e;
endpackage

// File: rtl/tmr_clk_select.sv
module tmr_clk_select #(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin_i,
    input  logic use_ext_i,
    input  logic bypass_i,
    output logic pulse_o
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int CW = SYNC_STAGES + 1;

    logic [TW-1:0] tick_q;
    logic [CW-1:0] chain_q;
    logic          int_pulse;
    logic          edge_sync;
    logic          edge_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_q == TW'(TICK_DIV - 1)) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= ext_pin_i;
        end
    end

    for (genvar i = 1; i < CW; i++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[i] <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    always_comb begin
        int_pulse = (tick_q == TW'(TICK_DIV - 1));
        edge_sync = chain_q[CW-2] & ~chain_q[CW-1];
        edge_raw  = chain_q[0] & ~chain_q[1];
        if (use_ext_i) begin
            pulse_o = bypass_i ? edge_raw : edge_sync;
        end else begin
            pulse_o = int_pulse;
        end
    end

    // R4
    sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sync |-> $past(chain_q[0]));
endmodule

// File: rtl/tmr_gate_fsm.sv
module tmr_gate_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic gate_en_i,
    input  logic gate_lvl_i,
    input  logic gate_sel_i,
    input  logic gate_pin_i,
    input  logic cmp_i,
    output logic run_o
);
    gate_state_e state_q;
    gate_state_e state_d;
    logic        gate_in;
    logic        gate_open;

    always_comb begin
        gate_in   = gate_sel_i ? cmp_i : gate_pin_i;
        gate_open = !gate_en_i || (gate_in == gate_lvl_i);
        state_d   = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (on_i) begin
                    state_d = gate_open ? ST_RUN : ST_PAUSE;
                end
            end
            ST_RUN: begin
                if (!on_i) begin
                    state_d = ST_OFF;
                end else if (!gate_open) begin
                    state_d = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (!on_i) begin
                    state_d = ST_OFF;
                end else if (gate_open) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
    end

    // R5
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> !run_o);

    // R6
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_i && !gate_en_i |=> run_o);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             step_o
);
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = PW'((32'd1 << sel_i) - 32'd1);
        step_o = pulse_i && (pre_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (pulse_i) begin
            pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
        end
    end

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !pulse_i |=> $stable(pre_q));

    // R9
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> pre_q == '0);
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import tmr_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_clk_pin,
    input  logic       gate_pin,
    input  logic       cmp_level,
    output logic       irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BYTE_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              ie_q;
    logic              gsel_q;

    logic wr_ctrl, wr_low, wr_high, wr_aux, wr_cnt;
    logic src_pulse, run, step, wrap;

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_low  = bus_we && (bus_addr == A_LOW);
        wr_high = bus_we && (bus_addr == A_HIGH);
        wr_aux  = bus_we && (bus_addr == A_AUX);
        wr_cnt  = wr_low || wr_high;
        wrap    = step && !wr_cnt && (cnt_q == CNT_MAX);
    end

    tmr_clk_select #(
        .TICK_DIV   (TICK_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin_i(ext_clk_pin),
        .use_ext_i(ctrl_q[B_EXT]),
        .bypass_i (ctrl_q[B_BYPASS]),
        .pulse_o  (src_pulse)
    );

    tmr_gate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_i      (ctrl_q[B_ON]),
        .gate_en_i (ctrl_q[B_GEN]),
        .gate_lvl_i(ctrl_q[B_GLVL]),
        .gate_sel_i(gsel_q),
        .gate_pin_i(gate_pin),
        .cmp_i     (cmp_level),
        .run_o     (run)
    );

    tmr_prescale #(
        .SEL_W(2)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wr_ctrl || wr_cnt),
        .pulse_i(run && src_pulse),
        .sel_i  (ctrl_q[B_PS_HI:B_PS_LO]),
        .step_o (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_low) begin
            cnt_q[BYTE_W-1:0] <= bus_wdata;
        end else if (wr_high) begin
            cnt_q[CNT_W-1:BYTE_W] <= bus_wdata;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            gsel_q <= 1'b1;
        end else begin
            if (wr_aux) begin
                ie_q   <= bus_wdata[X_IE];
                gsel_q <= bus_wdata[X_GSEL];
            end
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (wr_aux) begin
                flag_q <= bus_wdata[X_FLAG];
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_LOW:   bus_rdata = cnt_q[BYTE_W-1:0];
            A_HIGH:  bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            default: bus_rdata = {5'b0, gsel_q, ie_q, flag_q};
        endcase
        irq = flag_q & ie_q;
    end

    // R9
    cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt && !step |=> $stable(cnt_q));

    // R10
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_cnt && (cnt_q == CNT_MAX) |=> flag_q && (cnt_q == '0));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !wr_aux |=> flag_q);

    // R5
    off_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !step);
endmodule

// File: tb/tb_gated_timer16.sv
module tb_gated_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_pin = 1'b0;
    logic       gate_pin = 1'b0;
    logic       cmp_level = 1'b0;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    gated_timer16 dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_clk_pin(ext_clk_pin),
        .gate_pin   (gate_pin),
        .cmp_level  (cmp_level),
        .irq        (irq)
    );

    always #10 clk = ~clk;

    // reference model state
    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt;
    bit          m_flag, m_ie, m_sel, m_run;
    int          m_pre, m_tick;
    bit          m_s1, m_s2, m_s3;

    always @(posedge clk) begin : model
        int div;
        bit ip, eg, src, inc, glvl, nrun, cw;
        if (!rst_n) begin
            m_ctrl = 8'h00; m_cnt = 16'h0000;
            m_flag = 0; m_ie = 0; m_sel = 1; m_run = 0;
            m_pre = 0; m_tick = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            div  = 1 << m_ctrl[5:4];
            ip   = (m_tick == 3);
            eg   = m_ctrl[2] ? (m_s1 && !m_s2) : (m_s2 && !m_s3);
            src  = m_ctrl[1] ? eg : ip;
            glvl = m_sel ? cmp_level : gate_pin;
            nrun = m_ctrl[0] && (!m_ctrl[6] || (glvl == m_ctrl[7]));
            cw   = bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2);
            inc  = 0;
            if (m_run && src) begin
                if (m_pre + 1 >= div) begin m_pre = 0; inc = 1; end
                else m_pre = m_pre + 1;
            end
            if (bus_we) begin
                case (bus_addr)
                    2'd0: begin m_ctrl = bus_wdata; m_pre = 0; end
                    2'd1: begin m_cnt[7:0] = bus_wdata; m_pre = 0; end
                    2'd2: begin m_cnt[15:8] = bus_wdata; m_pre = 0; end
                    default: begin
                        m_flag = bus_wdata[0];
                        m_ie   = bus_wdata[1];
                        m_sel  = bus_wdata[2];
                    end
                endcase
            end
            if (inc && !cw) begin
                if (m_cnt == 16'hFFFF) m_flag = 1;
                m_cnt = m_cnt + 16'd1;
            end
            m_run  = nrun;
            m_tick = (m_tick + 1) % 4;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_pin;
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_cnt[7:0];
            2'd2:    return m_cnt[15:8];
            default: return {5'b0, m_sel, m_ie, m_flag};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        if (rst_n && !done) begin
            #2;
            case (bus_addr)
                2'd0:    chk("R2 ctrl read", {8'h0, bus_rdata}, {8'h0, m_read(2'd0)});
                2'd1:    chk("R8 low read", {8'h0, bus_rdata}, {8'h0, m_read(2'd1)});
                2'd2:    chk("R8 high read", {8'h0, bus_rdata}, {8'h0, m_read(2'd2)});
                default: chk("R10 aux read", {8'h0, bus_rdata}, {8'h0, m_read(2'd3)});
            endcase
            chk("R11 irq", {15'h0, irq}, {15'h0, m_flag & m_ie});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, {8'h0, bus_rdata}, {8'h0, m_read(a)});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_toggle(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            repeat (half) @(negedge clk);
            ext_clk_pin = ~ext_clk_pin;
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        report();
    end

    initial begin
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, literal values
        bus_addr = 2'd0; #1; chk("R1 ctrl", {8'h0, bus_rdata}, 16'h0000);
        bus_addr = 2'd1; #1; chk("R1 low", {8'h0, bus_rdata}, 16'h0000);
        bus_addr = 2'd2; #1; chk("R1 high", {8'h0, bus_rdata}, 16'h0000);
        bus_addr = 2'd3; #1; chk("R1 aux", {8'h0, bus_rdata}, 16'h0004);
        chk("R1 irq", {15'h0, irq}, 16'h0000);

        // R2 control readback, R3 internal tick at 1:1
        wr(2'd0, 8'h01);
        rd(2'd0, "R2 ctrl readback");
        idle(40);
        rd(2'd1, "R3 internal tick count");

        // R8 each prescale value
        for (int ps = 0; ps < 4; ps++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, 8'h01 | 8'(ps << 4));
            idle(70);
            rd(2'd1, "R8 prescale count");
        end

        // R9 write mid-prescale clears the divider and loads the byte
        wr(2'd0, 8'h31);
        idle(13);
        wr(2'd1, 8'h80);
        rd(2'd1, "R9 low byte load");
        wr(2'd2, 8'h12);
        rd(2'd2, "R9 high byte load");
        idle(40);
        rd(2'd1, "R9 count after clear");

        // R4 external clock, synchronized then bypassed
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        wr(2'd0, 8'h03);
        ext_toggle(20, 3);
        rd(2'd1, "R4 external sync count");
        wr(2'd0, 8'h07);
        ext_toggle(20, 2);
        rd(2'd1, "R4 external bypass count");

        // R6 and R7 gate on pin (select 0), both polarities
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h41);
        for (int i = 0; i < 6; i++) begin
            idle(9); gate_pin = ~gate_pin;
            rd(2'd1, "R6 gate low-active");
        end
        wr(2'd0, 8'hC1);
        for (int i = 0; i < 6; i++) begin
            idle(7); gate_pin = ~gate_pin;
            rd(2'd1, "R6 gate high-active");
        end
        // comparator selected; pin toggles must not matter
        wr(2'd3, 8'h04);
        for (int i = 0; i < 6; i++) begin
            idle(5); cmp_level = ~cmp_level; gate_pin = ~gate_pin;
            rd(2'd1, "R7 comparator gate");
        end
        // R6 gate enable 0 counts freely whatever the gate
        wr(2'd0, 8'h81);
        cmp_level = 1'b0;
        idle(20);
        rd(2'd1, "R6 free running");

        // R5 on bit 0 with gating: count frozen
        wr(2'd0, 8'h40);
        bus_addr = 2'd1; #1; snap = bus_rdata;
        idle(30); cmp_level = 1'b1; gate_pin = 1'b1; idle(10);
        rd(2'd1, "R5 stopped model");
        chk("R5 stopped frozen", {8'h0, bus_rdata}, {8'h0, snap});

        // R12 oscillator bit has no effect
        wr(2'd0, 8'h09);
        rd(2'd0, "R12 osc readback");
        idle(24);
        rd(2'd1, "R12 count unaffected");

        // R10 and R11 overflow
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h02);
        wr(2'd0, 8'h01);
        idle(80);
        bus_addr = 2'd3; #1;
        chk("R10 flag set", {15'h0, bus_rdata[0]}, 16'h0001);
        chk("R11 irq asserted", {15'h0, irq}, 16'h0001);
        idle(10);
        rd(2'd3, "R10 flag sticky");
        wr(2'd3, 8'h02);
        bus_addr = 2'd3; #1;
        chk("R10 flag cleared", {15'h0, bus_rdata[0]}, 16'h0000);
        chk("R11 irq released", {15'h0, irq}, 16'h0000);
        wr(2'd3, 8'h01);
        rd(2'd3, "R11 masked flag");
        chk("R11 irq masked", {15'h0, irq}, 16'h0000);

        idle(3);
        done = 1'b1;
        report();
    end
endmodule